// File: doc/BRIEF.md
# Serial-Access User Flash Controller

This block is a behavioural model of a small on-chip non-volatile user memory that is reached through two serial shift registers. One register holds a word address and the other holds a 16-bit data word. User logic shifts an address in, pulses a read strobe to copy the addressed word into the data register, then shifts that word out one bit per data-clock strobe, most significant bit first. A stream read needs no new address for each word. Clocking the address strobe with its shift-enable low steps the stored address forward by one.

Writes use two commands. A program request clears bits of the addressed word, so only ones that are also zero in the data register turn to zero. An erase request sets every word to all ones. The requester holds the request high. The block then runs a timed sequence on its own and raises busy while it works. The falling edge of busy signals completion. If the request drops before busy falls, the operation is abandoned, an error flag is raised and the affected words are left at all ones. A divide-by-four copy of the internal time base is exported as a clock for user logic.

All inputs are synchronous to `clk`. The address and data "clocks" are single-cycle strobes sampled on `clk`, and `clk` also stands in for the internal oscillator.

Top module: `serial_user_flash`

## Requirements
- R1: On a cycle with `addrClkEn` high and `addrShiftEn` high, the address register shifts left by one and takes `addrSerIn` into its LSB. After ADDR_W such strobes, the first bit sent is the address MSB.
- R2: On a cycle with `addrClkEn` high and `addrShiftEn` low, the address increments by one, and the all-ones address wraps to 0.
- R3: A `readStb` pulse copies the addressed word into the data register. `dataSerOut` always shows data-register bit 15. Each cycle with `dataClkEn` and `dataShiftEn` both high shifts the register left, with `dataSerIn` entering bit 0.
- R4: An erase request sampled in idle raises `busy` on the next cycle for exactly ERASE_CYC cycles. It then leaves every word at 16'hFFFF.
- R5: A program request sampled in idle raises `busy` on the next cycle for exactly PROG_CYC cycles. It then leaves the addressed word equal to its old value ANDed with the data register.
- R6: After a completed operation, `busy` stays low and no new operation starts while either request is still held. A new one starts only after both requests have been seen low.
- R7: Dropping the active request while `busy` is high ends the operation on the next cycle, with `busy` low and `errFlag` high. For a program the addressed word becomes 16'hFFFF, and for an erase every word becomes 16'hFFFF. `errFlag` clears when the next operation starts.
- R8: While `busy` is high, address strobes, data strobes and `readStb` have no effect on the address register or the data register.
- R9: `oscDiv4` has a period of four `clk` cycles. After reset it is low for the first two cycles and then high for two.
- R10: `rstN` low clears the address register, the data register, the divider, `busy` and `errFlag`, and leaves the array contents unchanged.
- R11: If program and erase are both requested in the same idle cycle, the program runs and the erase is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the model's oscillator |
| rstN | input | 1 | Active-low synchronous reset |
| addrClkEn | input | 1 | Address-clock strobe |
| addrShiftEn | input | 1 | High: shift address bit in; low: increment |
| addrSerIn | input | 1 | Serial address bit |
| dataClkEn | input | 1 | Data-clock strobe |
| dataShiftEn | input | 1 | Enables the data shift on a data strobe |
| dataSerIn | input | 1 | Serial data bit into the data register LSB |
| dataSerOut | output | 1 | Data register MSB |
| readStb | input | 1 | Load addressed word into data register |
| progReq | input | 1 | Held program request |
| eraseReq | input | 1 | Held erase request |
| busy | output | 1 | Operation in progress |
| errFlag | output | 1 | Last operation was aborted |
| oscDiv4 | output | 1 | Oscillator divided by four |

## Verification
The bench builds the block with a 4-bit address (16 words), PROG_CYC of 5 and ERASE_CYC of 9. With these values, every word can be programmed twice with distinct patterns and read back as a stream, and the wrap from the last address to word 0 falls inside the same sweep. The short busy windows mean the exact busy length, the abort paths and the hold-after-completion behaviour can each be timed cycle by cycle against a word model kept in the bench.

// File: rtl/serial_user_flash_pkg.sv
package serial_user_flash_pkg;

  // Array-update strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic progWrite;  // AND data register into addressed word
    logic fillWord;   // aborted program: addressed word to all ones
    logic eraseAll;   // erase complete or aborted: whole array to ones
  } flashStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2,
    ST_HOLD  = 2'd3
  } flashState_t;

endpackage

// File: rtl/serial_user_flash_osc.sv
module serial_user_flash_osc #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic divOut
);

  logic [DIV_LOG2-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign divOut = divCnt[DIV_LOG2-1];

  // R9: each half period lasts more than one cycle
  a_r9_high_half: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divOut) |=> divOut);
  a_r9_low_half: assert property (@(posedge clk) disable iff (!rstN)
    $fell(divOut) |=> !divOut);

endmodule

// File: rtl/serial_user_flash_ctrl.sv
module serial_user_flash_ctrl
  import serial_user_flash_pkg::*;
#(
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progReq,
  input  logic       eraseReq,
  output logic       busy,
  output logic       errFlag,
  output flashStrb_t strb
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);

  flashState_t state;
  logic [CNT_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cycCnt  <= '0;
      errFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cycCnt <= '0;
          if (progReq) begin
            state   <= ST_PROG;
            errFlag <= 1'b0;
          end else if (eraseReq) begin
            state   <= ST_ERASE;
            errFlag <= 1'b0;
          end
        end
        ST_PROG: begin
          if (!progReq) begin
            state   <= ST_IDLE;
            errFlag <= 1'b1;
          end else if (cycCnt == PROG_LAST) begin
            state <= ST_HOLD;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_ERASE: begin
          if (!eraseReq) begin
            state   <= ST_IDLE;
            errFlag <= 1'b1;
          end else if (cycCnt == ERASE_LAST) begin
            state <= ST_HOLD;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!progReq && !eraseReq) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_PROG) || (state == ST_ERASE);

  always_comb begin
    strb.progWrite = (state == ST_PROG) && progReq && (cycCnt == PROG_LAST);
    strb.fillWord  = (state == ST_PROG) && !progReq;
    strb.eraseAll  = (state == ST_ERASE) && (!eraseReq || (cycCnt == ERASE_LAST));
  end

  // R5/R4: the sequence counter never runs past its limit
  a_r5_prog_window: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> (cycCnt <= PROG_LAST));
  a_r4_erase_window: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE) |-> (cycCnt <= ERASE_LAST));
  // R7: early release aborts and flags
  a_r7_abort_flags: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (state == ST_PROG) && !progReq) |=> (errFlag && !busy));
  // R6: held request after completion does not restart
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> !busy);
  // at most one array strobe per cycle
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.progWrite, strb.fillWord, strb.eraseAll}));

endmodule

// File: rtl/serial_user_flash_dp.sv
module serial_user_flash_dp
  import serial_user_flash_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  flashStrb_t strb,
  input  logic       addrClkEn,
  input  logic       addrShiftEn,
  input  logic       addrSerIn,
  input  logic       dataClkEn,
  input  logic       dataShiftEn,
  input  logic       dataSerIn,
  input  logic       readStb,
  output logic       dataSerOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rdWord;

  assign rdWord = mem[addrReg];

  // Array: no reset, contents survive rstN
  always_ff @(posedge clk) begin
    if (strb.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.fillWord) begin
      mem[addrReg] <= '1;
    end else if (strb.progWrite) begin
      mem[addrReg] <= rdWord & dataReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (!busy && addrClkEn) begin
      if (addrShiftEn) addrReg <= {addrReg[ADDR_W-2:0], addrSerIn};
      else             addrReg <= addrReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (!busy) begin
      if (readStb)                       dataReg <= rdWord;
      else if (dataClkEn && dataShiftEn) dataReg <= {dataReg[DATA_W-2:0], dataSerIn};
    end
  end

  assign dataSerOut = dataReg[DATA_W-1];

  // R8: registers frozen while busy
  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrReg));
  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(dataReg));
  // R2: increment wraps to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && addrClkEn && !addrShiftEn && (addrReg == '1)) |=> (addrReg == '0));
  // R3: read strobe captures the addressed word
  a_r3_read_load: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && readStb) |=> (dataReg == $past(rdWord)));

endmodule

// File: rtl/serial_user_flash.sv
module serial_user_flash
  import serial_user_flash_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrClkEn,
  input  logic addrShiftEn,
  input  logic addrSerIn,
  input  logic dataClkEn,
  input  logic dataShiftEn,
  input  logic dataSerIn,
  output logic dataSerOut,
  input  logic readStb,
  input  logic progReq,
  input  logic eraseReq,
  output logic busy,
  output logic errFlag,
  output logic oscDiv4
);

  flashStrb_t strb;

  serial_user_flash_ctrl #(
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .progReq (progReq),
    .eraseReq(eraseReq),
    .busy    (busy),
    .errFlag (errFlag),
    .strb    (strb)
  );

  serial_user_flash_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(16)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .strb       (strb),
    .addrClkEn  (addrClkEn),
    .addrShiftEn(addrShiftEn),
    .addrSerIn  (addrSerIn),
    .dataClkEn  (dataClkEn),
    .dataShiftEn(dataShiftEn),
    .dataSerIn  (dataSerIn),
    .readStb    (readStb),
    .dataSerOut (dataSerOut)
  );

  serial_user_flash_osc #(
    .DIV_LOG2(2)
  ) u_osc (
    .clk   (clk),
    .rstN  (rstN),
    .divOut(oscDiv4)
  );

endmodule

// File: tb/serial_user_flash_tb.sv
module serial_user_flash_tb;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PCYC  = 5;
  localparam int ECYC  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrClkEn = 0, addrShiftEn = 0, addrSerIn = 0;
  logic dataClkEn = 0, dataShiftEn = 0, dataSerIn = 0;
  logic readStb = 0, progReq = 0, eraseReq = 0;
  logic dataSerOut, busy, errFlag, oscDiv4;

  int nChecks = 0;
  int nErr = 0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  serial_user_flash #(.ADDR_W(AW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u_dut (
    .clk(clk), .rstN(rstN),
    .addrClkEn(addrClkEn), .addrShiftEn(addrShiftEn), .addrSerIn(addrSerIn),
    .dataClkEn(dataClkEn), .dataShiftEn(dataShiftEn), .dataSerIn(dataSerIn),
    .dataSerOut(dataSerOut), .readStb(readStb),
    .progReq(progReq), .eraseReq(eraseReq),
    .busy(busy), .errFlag(errFlag), .oscDiv4(oscDiv4)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic shiftAddr(input int a);
    addrClkEn = 1; addrShiftEn = 1;
    for (int i = AW - 1; i >= 0; i--) begin
      addrSerIn = a[i];
      tick();
    end
    addrClkEn = 0; addrShiftEn = 0; addrSerIn = 0;
  endtask

  task automatic incAddr;
    addrClkEn = 1; addrShiftEn = 0;
    tick();
    addrClkEn = 0;
  endtask

  task automatic shiftData(input logic [15:0] w, output logic [15:0] got);
    dataClkEn = 1; dataShiftEn = 1;
    for (int i = 15; i >= 0; i--) begin
      got[i] = dataSerOut;
      dataSerIn = w[i];
      tick();
    end
    dataClkEn = 0; dataShiftEn = 0; dataSerIn = 0;
  endtask

  task automatic readCur(output logic [15:0] v);
    readStb = 1;
    tick();
    readStb = 0;
    shiftData(16'h0000, v);
  endtask

  task automatic runOp(input logic p, input logic e, output int n);
    progReq = p; eraseReq = e;
    tick();
    n = 0;
    while (busy && n < 5000) begin
      n++;
      tick();
    end
    for (int k = 0; k < 3; k++) begin  // R6 hold phase
      chk("R6 busy stays low while held", busy, 0);
      tick();
    end
    chk("R6 errFlag after clean finish", errFlag, 0);
    progReq = 0; eraseReq = 0;
    tick();
  endtask

  task automatic verifyAll(input string req);
    logic [15:0] v;
    shiftAddr(0);
    for (int a = 0; a < DEPTH; a++) begin
      readCur(v);
      chk(req, v, model[a]);
      incAddr();
    end
    readCur(v);  // R2 wrap back to word 0
    chk("R2 wrap to word 0", v, model[0]);
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] pat;
    int n;
    tick(); tick();
    chk("R10 busy in reset", busy, 0);
    chk("R10 errFlag in reset", errFlag, 0);
    chk("R10 oscDiv4 in reset", oscDiv4, 0);
    chk("R10 dataSerOut in reset", dataSerOut, 0);
    rstN = 1;
    for (int k = 1; k <= 12; k++) begin
      tick();
      chk("R9 divide by four", oscDiv4, ((k % 4) >= 2) ? 1 : 0);
    end

    // R4 erase
    runOp(0, 1, n);
    chk("R4 erase busy length", n, ECYC);
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    verifyAll("R4 erased word");

    // R5 program every word twice, R1 address shift, R3 serial data
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < DEPTH; a++) begin
        pat = (pass == 0) ? (16'hA5C3 ^ 16'(a * 16'h1111)) : (16'hF0F0 ^ 16'(a * 16'h0123));
        shiftAddr(a);
        shiftData(pat, v);
        runOp(1, 0, n);
        chk("R5 program busy length", n, PCYC);
        model[a] = model[a] & pat;
      end
      verifyAll("R5 R1 R3 programmed word");
    end

    // R8 strobes ignored while busy
    shiftAddr(5);
    shiftData(16'h3C3C, v);
    progReq = 1;
    tick();
    addrClkEn = 1; addrShiftEn = 1; addrSerIn = 1; readStb = 1;
    dataClkEn = 1; dataShiftEn = 1; dataSerIn = 0;
    n = 0;
    while (busy && n < 100) begin n++; tick(); end
    addrClkEn = 0; addrShiftEn = 0; addrSerIn = 0; readStb = 0;
    dataClkEn = 0; dataShiftEn = 0;
    progReq = 0;
    tick();
    model[5] = model[5] & 16'h3C3C;
    shiftData(16'h0000, v);
    chk("R8 data register kept", v, 16'h3C3C);
    readCur(v);
    chk("R8 address kept", v, model[5]);

    // R7 program abort
    shiftAddr(3);
    shiftData(16'h0000, v);
    progReq = 1;
    tick(); tick();
    chk("R7 busy before release", busy, 1);
    progReq = 0;
    tick();
    chk("R7 busy after abort", busy, 0);
    chk("R7 errFlag after abort", errFlag, 1);
    model[3] = 16'hFFFF;
    verifyAll("R7 program abort word");

    // R10 reset keeps array, clears registers and flag
    shiftAddr(9);
    shiftData(16'hFFFF, v);
    rstN = 0;
    tick();
    chk("R10 errFlag cleared", errFlag, 0);
    chk("R10 data register cleared", dataSerOut, 0);
    rstN = 1;
    readCur(v);
    chk("R10 array kept, address zero", v, model[0]);

    // R7 erase abort then error clears on next op
    eraseReq = 1;
    tick(); tick(); tick();
    eraseReq = 0;
    tick();
    chk("R7 erase abort flag", errFlag, 1);
    chk("R7 erase abort busy", busy, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 16'hFFFF;
    verifyAll("R7 erase abort word");
    shiftAddr(2);
    shiftData(16'h1234, v);
    progReq = 1;
    tick();
    chk("R7 errFlag cleared on new op", errFlag, 0);
    progReq = 0;
    tick();
    model[2] = 16'hFFFF;

    // R11 program wins over erase
    shiftAddr(7);
    shiftData(16'h00FF, v);
    runOp(1, 1, n);
    chk("R11 busy length is program", n, PCYC);
    model[7] = model[7] & 16'h00FF;
    verifyAll("R11 only addressed word changed");

    finishRun();
  end

endmodule